// File: doc/BRIEF.md
# Row-Column 8x8 Forward DCT

This block takes an 8x8 tile of unsigned 8-bit pixels, one pixel per accepted clock, and returns the 64 coefficients of its two-dimensional forward DCT together, on a single-cycle strobe. The pixels arrive in raster order: row 0 first, left to right, then row 1, and so on. The block centres each pixel on zero by subtracting 128. It then runs two cascaded one-dimensional transforms.

The horizontal pass is one serial-in, parallel-out unit with eight multiply-accumulate lanes. Each lane weights the incoming pixel by one cosine basis coefficient. Every eighth accepted pixel, this pass hands an eight-entry intermediate vector to the vertical pass. The vertical pass has eight identical units, and each one consumes one entry of that vector. Because the rows are processed in the order they arrive, no transpose memory and no sequencing state machine are needed. A new tile may start on the clock after the last pixel of the previous one. The fixed-point precision of the cosine weights is set by a parameter. Each output is rounded to the nearest integer.

Top module: `fdct_rowcol`

## Requirements
- R1: From reset until the first complete tile has been transformed, `valid_o` stays low.
- R2: `pix_i` is an unsigned 8-bit pixel. It is accepted on each rising edge where `pix_valid_i` is high. Before the transform, the block uses the value `pix_i - 128`.
- R3: The pixel accepted at position r·8+n within a tile (row r, column n) is x(r,n). When `valid_o` is high, coefficient (p,k) sits at `coef_o[(8p+k)*OUT_W +: OUT_W]` as a two's-complement value. It lies within ±1 of cp·ck·Σ(x(r,n)−128)·cos((2r+1)pπ/16)·cos((2n+1)kπ/16), where c0=√(1/8) and cm=1/2 for m>0.
- R4: `valid_o` is observed high after the fifth rising edge that follows the edge which accepts the 64th pixel of a tile.
- R5: Each tile raises `valid_o` for exactly one cycle, and no further strobe appears until another tile completes.
- R6: Cycles with `pix_valid_i` low are ignored, whatever `pix_i` holds. Gaps inside a tile leave its coefficients unchanged and shift the strobe only with the last accepted pixel.
- R7: Tiles may be streamed with no idle cycle between them. The strobes of two such tiles are exactly 64 edges apart, and each tile's result is independent of its neighbour's.
- R8: A tile in which every pixel equals v yields a DC term within ±1 of 8·(v−128), and every other coefficient is exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Unsigned pixel sample |
| pix_valid_i | input | 1 | Pixel qualifier |
| coef_o | output | 64*OUT_W | Coefficients; entry 8p+k holds vertical frequency p, horizontal frequency k |
| valid_o | output | 1 | One-cycle strobe marking a complete coefficient set |

## Verification
The assertions assume that every tile is delivered as exactly 64 qualified pixels, and that no pixel is qualified while reset is asserted. Under those assumptions, the internal row strobe can follow only from pixels accepted three edges earlier. The assertions also assume that the DC term stays inside the range an 8-bit source can produce. The bench keeps within these assumptions: it always sends whole tiles, raises `pix_valid_i` only after reset is released, and inserts idle cycles only between pixels of the same tile or between tiles.

// File: rtl/fdct_pkg.sv
package fdct_pkg;

    localparam int BLK   = 8;
    localparam int CNT_W = $clog2(BLK);

    // cos(k*pi/16) for any non-negative k, folded onto the first quadrant
    function automatic real cos16(input int k);
        int  kk;
        real v;
        kk = k % 32;
        if (kk > 16) kk = 32 - kk;
        if (kk > 8) return -cos16(16 - kk);
        case (kk)
            0:       v = 1.0;
            1:       v = 0.9807852804;
            2:       v = 0.9238795325;
            3:       v = 0.8314696123;
            4:       v = 0.7071067812;
            5:       v = 0.5555702330;
            6:       v = 0.3826834324;
            7:       v = 0.1950903220;
            default: v = 0.0;
        endcase
        return v;
    endfunction

    // basis weight for frequency m at sample n, scaled by 2^frac, nearest integer
    function automatic int dct_coef(input int m, input int n, input int frac);
        real scale;
        real cm;
        scale = 1.0;
        for (int i = 0; i < frac; i++) scale = scale * 2.0;
        cm = (m == 0) ? 0.3535533906 : 0.5;
        return int'(cm * cos16((2 * n + 1) * m) * scale);
    endfunction

endpackage

// File: rtl/fdct_mac.sv
module fdct_mac #(
    parameter int IN_W  = 9,
    parameter int CW    = 14,
    parameter int ACC_W = IN_W + CW + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mul_en_i,
    input  logic [IN_W-1:0]  x_i,
    input  logic [CW-1:0]    coef_i,
    input  logic             acc_en_i,
    input  logic             acc_clr_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam int PW = IN_W + CW;

    typedef struct packed {
        logic [PW-1:0]    prod;
        logic [ACC_W-1:0] acc;
    } mac_t;

    mac_t mac_d, mac_q;

    always_comb begin
        mac_d = mac_q;
        if (mul_en_i) begin
            mac_d.prod = PW'($signed(x_i) * $signed(coef_i));
        end
        if (acc_en_i) begin
            if (acc_clr_i) begin
                mac_d.acc = ACC_W'($signed(mac_q.prod));
            end else begin
                mac_d.acc = ACC_W'($signed(mac_q.acc) + $signed(ACC_W'($signed(mac_q.prod))));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mac_q <= '0;
        else        mac_q <= mac_d;
    end

    assign acc_o = mac_q.acc;

endmodule

// File: rtl/fdct_1d.sv
module fdct_1d #(
    parameter int IN_W  = 9,
    parameter int FRAC  = 12,
    parameter int CW    = FRAC + 2,
    parameter int ACC_W = IN_W + CW + 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid_i,
    input  logic [IN_W-1:0]               in_x_i,
    output logic                          out_valid_o,
    output logic [fdct_pkg::BLK*ACC_W-1:0] out_vec_o
);
    import fdct_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             p_valid;
        logic             p_first;
        logic             p_last;
        logic             o_valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [CW-1:0] ctab [BLK][BLK];

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.p_valid = in_valid_i;
        ctl_d.p_first = in_valid_i && (ctl_q.cnt == '0);
        ctl_d.p_last  = in_valid_i && (ctl_q.cnt == CNT_W'(BLK - 1));
        ctl_d.o_valid = ctl_q.p_valid && ctl_q.p_last;
        if (in_valid_i) ctl_d.cnt = ctl_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar m = 0; m < BLK; m++) begin : g_lane
        for (genvar n = 0; n < BLK; n++) begin : g_tap
            localparam int C_MN = dct_coef(m, n, FRAC);
            assign ctab[m][n] = CW'(C_MN);
        end
        fdct_mac #(.IN_W(IN_W), .CW(CW), .ACC_W(ACC_W)) u_mac (
            .clk      (clk),
            .rst_n    (rst_n),
            .mul_en_i (in_valid_i),
            .x_i      (in_x_i),
            .coef_i   (ctab[m][ctl_q.cnt]),
            .acc_en_i (ctl_q.p_valid),
            .acc_clr_i(ctl_q.p_first),
            .acc_o    (out_vec_o[m*ACC_W +: ACC_W])
        );
    end

    assign out_valid_o = ctl_q.o_valid;

    // R5: a vector strobe never lasts more than one cycle
    a_r5_vec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o);

endmodule

// File: rtl/fdct_rowcol.sv
module fdct_rowcol #(
    parameter int FRAC  = 12,
    parameter int OUT_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         pix_i,
    input  logic               pix_valid_i,
    output logic [64*OUT_W-1:0] coef_o,
    output logic               valid_o
);
    import fdct_pkg::*;

    localparam int SW = 9;
    localparam int CW = FRAC + 2;
    localparam int W1 = SW + CW + 3;
    localparam int W2 = W1 + CW + 3;
    localparam logic [W2-1:0] HALF = W2'(64'd1 << (2 * FRAC - 1));

    typedef struct packed {
        logic          s1_valid;
        logic [SW-1:0] s1_pix;
        logic          s2_valid;
        logic [SW-1:0] s2_pix;
    } front_t;

    front_t fr_d, fr_q;

    always_comb begin
        fr_d          = fr_q;
        fr_d.s1_valid = pix_valid_i;
        fr_d.s1_pix   = {1'b0, pix_i};
        fr_d.s2_valid = fr_q.s1_valid;
        fr_d.s2_pix   = fr_q.s1_pix - SW'(128);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    logic              row_valid;
    logic [BLK*W1-1:0] row_vec;
    logic [BLK-1:0]    col_valid;

    fdct_1d #(.IN_W(SW), .FRAC(FRAC), .CW(CW), .ACC_W(W1)) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (fr_q.s2_valid),
        .in_x_i     (fr_q.s2_pix),
        .out_valid_o(row_valid),
        .out_vec_o  (row_vec)
    );

    for (genvar k = 0; k < BLK; k++) begin : g_col
        logic [BLK*W2-1:0] col_vec;
        fdct_1d #(.IN_W(W1), .FRAC(FRAC), .CW(CW), .ACC_W(W2)) u_col (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid_i (row_valid),
            .in_x_i     (row_vec[k*W1 +: W1]),
            .out_valid_o(col_valid[k]),
            .out_vec_o  (col_vec)
        );
        for (genvar p = 0; p < BLK; p++) begin : g_rnd
            logic [W2-1:0] rnd;
            assign rnd = col_vec[p*W2 +: W2] + HALF;
            assign coef_o[(p*BLK+k)*OUT_W +: OUT_W] = rnd[2*FRAC +: OUT_W];
        end
    end

    assign valid_o = col_valid[0];

    // R4: a row vector only follows a pixel accepted four sampling edges back
    a_r4_row_after_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |-> $past(pix_valid_i, 4));

    // R4: the output strobe trails the last row vector by two edges
    a_r4_out_after_row: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(row_valid, 2));

    // R7: the eight column units stay in lock step
    a_r7_cols_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid == '0) || (col_valid == '1));

    // R5: output strobe is one cycle wide
    a_r5_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: the DC term stays within what an 8-bit tile can produce
    a_r8_dc_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($signed(coef_o[OUT_W-1:0]) >= -1024 && $signed(coef_o[OUT_W-1:0]) <= 1017));

endmodule

// File: tb/fdct_rowcol_tb.sv
module fdct_rowcol_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int OUT_W      = 12;
    localparam real PI        = 3.14159265358979;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [7:0]          pix_i = '0;
    logic                pix_valid_i = 1'b0;
    logic [64*OUT_W-1:0] coef_o;
    logic                valid_o;

    fdct_rowcol #(.FRAC(12), .OUT_W(OUT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_i      (pix_i),
        .pix_valid_i(pix_valid_i),
        .coef_o     (coef_o),
        .valid_o    (valid_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int npulse   = 0;
    int width_err = 0;
    int pulse_cyc [8];
    int cap [8][64];
    bit prev_v = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (valid_o) begin
            if (prev_v) width_err++;
            else begin
                pulse_cyc[npulse % 8] = cyc;
                for (int i = 0; i < 64; i++)
                    cap[npulse % 8][i] = int'($signed(coef_o[i*OUT_W +: OUT_W]));
                npulse++;
            end
        end
        prev_v = valid_o;
    end

    always @(posedge clk) begin
        if (cyc == 100000) begin
            n_fail++;
            $display("FAIL R4 watchdog: cycle %0d expected below %0d", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic real ref_coef(input int pix [64], input int p, input int k);
        real s;
        real cp;
        real ck;
        s = 0.0;
        for (int r = 0; r < 8; r++)
            for (int n = 0; n < 8; n++)
                s += real'(pix[r*8+n] - 128) * $cos(real'((2*r+1)*p) * PI / 16.0)
                     * $cos(real'((2*n+1)*k) * PI / 16.0);
        cp = (p == 0) ? $sqrt(0.125) : 0.5;
        ck = (k == 0) ? $sqrt(0.125) : 0.5;
        return cp * ck * s;
    endfunction

    task automatic drive_block(input int pix [64], input bit gaps, output int last_edge);
        for (int i = 0; i < 64; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                pix_valid_i = 1'b0;
                pix_i       = 8'hA5;
            end
            @(negedge clk);
            pix_valid_i = 1'b1;
            pix_i       = 8'(pix[i]);
            last_edge   = cyc + 1;
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        pix_valid_i = 1'b0;
        pix_i       = 8'h5A;
    endtask

    task automatic wait_pulses(input int target);
        while (npulse < target) @(negedge clk);
        repeat (12) @(negedge clk);
        check(npulse == target, "R5", "strobes per tile", npulse, target);
        check(width_err == 0, "R5", "strobe width errors", width_err, 0);
    endtask

    task automatic check_block(input int pix [64], input int slot, input int last_edge, input string req);
        check(pulse_cyc[slot] == last_edge + 5, "R4", "strobe edge", pulse_cyc[slot], last_edge + 5);
        for (int i = 0; i < 64; i++) begin
            real e;
            e = ref_coef(pix, i / 8, i % 8);
            check((real'(cap[slot][i]) - e <= 1.0) && (e - real'(cap[slot][i]) <= 1.0),
                  req, $sformatf("R3 coefficient %0d", i), cap[slot][i], int'(e));
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1", "valid in reset", int'(valid_o), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(valid_o == 1'b0 && npulse == 0, "R1", "strobes before any tile", npulse, 0);
    endtask

    task automatic test_flat(input int v);
        int pix [64];
        int le;
        int base;
        int nz;
        foreach (pix[i]) pix[i] = v;
        base = npulse;
        drive_block(pix, 1'b0, le);
        go_idle();
        wait_pulses(base + 1);
        check((cap[base%8][0] - 8*(v-128) <= 1) && (8*(v-128) - cap[base%8][0] <= 1),
              "R8", "flat DC", cap[base%8][0], 8*(v-128));
        nz = 0;
        for (int i = 1; i < 64; i++) if (cap[base%8][i] != 0) nz++;
        check(nz == 0, "R8", "flat nonzero AC count", nz, 0);
        check_block(pix, base % 8, le, "R2");
    endtask

    task automatic test_pattern(input int kind, input bit gaps);
        int pix [64];
        int le;
        int base;
        int seed;
        seed = 12345 + kind;
        for (int i = 0; i < 64; i++) begin
            case (kind)
                0: pix[i] = (i * 4) % 256;
                1: pix[i] = (((i / 8) + (i % 8)) % 2 == 1) ? 255 : 0;
                default: begin
                    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
                    pix[i] = (seed >> 8) & 255;
                end
            endcase
        end
        base = npulse;
        drive_block(pix, gaps, le);
        go_idle();
        wait_pulses(base + 1);
        check_block(pix, base % 8, le, gaps ? "R6" : "R3");
    endtask

    task automatic test_back_to_back();
        int pa [64];
        int pb [64];
        int la;
        int lb;
        int base;
        for (int i = 0; i < 64; i++) begin
            pa[i] = (i * 37 + 11) % 256;
            pb[i] = 255 - ((i * 13) % 256);
        end
        base = npulse;
        drive_block(pa, 1'b0, la);
        drive_block(pb, 1'b0, lb);
        go_idle();
        wait_pulses(base + 2);
        check(pulse_cyc[(base+1)%8] - pulse_cyc[base%8] == 64, "R7", "strobe spacing",
              pulse_cyc[(base+1)%8] - pulse_cyc[base%8], 64);
        check_block(pa, base % 8, la, "R7");
        check_block(pb, (base + 1) % 8, lb, "R7");
    endtask

    initial begin
        test_reset();
        test_flat(0);
        test_flat(255);
        test_flat(128);
        test_pattern(0, 1'b0);
        test_pattern(1, 1'b0);
        test_pattern(2, 1'b0);
        test_pattern(3, 1'b1);
        test_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule